// File: doc/BRIEF.md
# Flash Access Protection Controller

This block guards a small on-chip flash array. Two requesters share it: the CPU and a debug port. Each one can ask for a byte read, a byte write, a page erase or a full device erase. The block checks every request against two protection layers and then either performs it on the flash model it contains or refuses it.

The first layer is a pair of software enable bits held in a control register: one enables writes, the other enables erases. The second layer is a security byte kept in the last byte of user flash. Its upper nibble can forbid the debug port from writing and erasing. Its lower nibble can also forbid the debug port from reading. Only a device erase issued by the debug port restores the array to all ones, and that is the only way to remove a lock. The region above the security byte is reserved and can never be accessed.

Each request receives a response one cycle later with a grant flag. A granted read also carries its data. Writes and erases then occupy the array for a fixed number of cycles, and any request made during that time is refused.

Top module: `flash_guard`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high in the next cycle, and `rsp_valid` is low otherwise. A refused request returns `rsp_grant`=0 and `rsp_rdata`=0x00, and leaves the array unchanged.
- R2: The array starts erased, with every byte at 0xFF. A CPU write (`req_src`=0, `req_op`=1) is granted only while the write-enable bit is 1. A granted write stores old AND new, so it can only clear bits.
- R3: A CPU page erase (`req_op`=2) is granted only while both the write-enable bit and the erase-enable bit are 1. It sets all bytes of the 2^PAGE_W-byte page that holds the address to 0xFF.
- R4: Any read, write or page erase at an address ≥ USER_BYTES is refused. The security byte sits at USER_BYTES-1. A page erase of the page that contains the security byte is refused for both sources.
- R5: If any bit 7..4 of the security byte is 0, debug writes and debug page erases are refused at every address except that a write to the security byte itself is still granted.
- R6: If any bit 3..0 of the security byte is 0, debug reads, writes and page erases are refused at every address, with the same exceptions: reading or writing the security byte itself.
- R7: CPU reads of user space are never blocked by the security byte. The security byte can always be read by either source, and the debug port can always clear its bits.
- R8: A device erase (`req_op`=3) is granted only from the debug port (`req_src`=1), whatever the address. It returns every byte, including the security byte, to 0xFF and so removes all locks.
- R9: After a granted write, page erase or device erase, `busy` is high for BUSY_CYCLES cycles, starting in the cycle of its response. Any request made while `busy` is high is refused.
- R10: A cycle with `ctl_we` high loads `ctl_wdata[0]` as write-enable and `ctl_wdata[1]` as erase-enable. Both are 0 after reset, and the new values govern requests made in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register load strobe |
| ctl_wdata | input | 2 | Bit 0 write-enable, bit 1 erase-enable |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | 1 | 0 CPU, 1 debug port |
| req_op | input | 2 | 0 read, 1 write, 2 page erase, 3 device erase |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_grant | output | 1 | 1 when that request was performed |
| rsp_rdata | output | 8 | Read data; 0x00 unless a granted read |
| busy | output | 1 | Array occupied by a write or erase |

## Verification
A request sampled at one rising edge has its grant flag and read data valid right after that edge. The array update happens at the same edge, so a read issued in the following cycle already sees the new contents. `busy` rises after that edge and stays high for BUSY_CYCLES cycles. The bench drives a request on a falling edge and reads each response on the next falling edge. After each granted write or erase it waits BUSY_CYCLES cycles, except in the one sequence where it issues a request during the busy window on purpose to see it refused.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_PERASE = 2'd2,
        OP_DERASE = 2'd3
    } fg_op_e;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_DBG = 1'b1
    } fg_src_e;

    typedef struct packed {
        logic wr_locked;
        logic rd_locked;
    } fg_lock_t;

    typedef struct packed {
        logic wen;
        logic een;
    } fg_ctl_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic fg_lock_t decode_lock(input logic [7:0] b);
        fg_lock_t r;
        r.wr_locked = ~&b[7:4];
        r.rd_locked = ~&b[3:0];
        return r;
    endfunction

endpackage

// File: rtl/fg_ctrl_reg.sv
module fg_ctrl_reg
    import flash_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] wdata,
    output fg_ctl_t    ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (we) begin
            ctl.wen <= wdata[0];
            ctl.een <= wdata[1];
        end
    end
endmodule

// File: rtl/fg_policy.sv
module fg_policy
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_W     = 9,
    parameter int USER_BYTES = 1536
) (
    input  fg_src_e           src,
    input  fg_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  fg_ctl_t           ctl,
    input  logic [7:0]        lock_byte,
    input  logic              busy,
    output logic              grant
);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(USER_BYTES - 1);

    fg_lock_t lk;
    logic     is_lock;
    logic     in_reserved;
    logic     lock_page;
    logic     any_lock;

    always_comb begin
        lk          = decode_lock(lock_byte);
        any_lock    = lk.wr_locked | lk.rd_locked;
        is_lock     = (addr == LOCK_A);
        in_reserved = (32'(addr) >= USER_BYTES);
        lock_page   = (addr[ADDR_W-1:PAGE_W] == LOCK_A[ADDR_W-1:PAGE_W]);
        grant       = 1'b0;
        if (busy) begin
            grant = 1'b0;
        end else if (op == OP_DERASE) begin
            grant = (src == SRC_DBG);
        end else if (in_reserved) begin
            grant = 1'b0;
        end else begin
            unique case (op)
                OP_READ:   grant = (src == SRC_CPU) || is_lock || !lk.rd_locked;
                OP_WRITE:  grant = (src == SRC_CPU) ? ctl.wen : (is_lock || !any_lock);
                OP_PERASE: begin
                    if (lock_page)
                        grant = 1'b0;
                    else
                        grant = (src == SRC_CPU) ? (ctl.wen & ctl.een) : !any_lock;
                end
                default:   grant = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fg_busy_timer.sv
module fg_busy_timer #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/fg_array.sv
module fg_array
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_W     = 9,
    parameter int USER_BYTES = 1536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              do_read,
    input  logic              do_write,
    input  logic              do_perase,
    input  logic              do_derase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [7:0]        lock_byte
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(USER_BYTES - 1);

    logic [7:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = ERASED_BYTE;
    end

    always_ff @(posedge clk) begin
        if (do_derase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (do_perase) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= ERASED_BYTE;
        end else if (do_write) begin
            mem[addr] <= mem[addr] & wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 8'h00;
        else
            rdata <= do_read ? mem[addr] : 8'h00;
    end

    assign lock_byte = mem[LOCK_A];
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 9,
    parameter int USER_BYTES  = 1536,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_wdata,
    input  logic              req_valid,
    input  logic              req_src,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [7:0]        rsp_rdata,
    output logic              busy
);
    fg_ctl_t    ctl;
    logic       wen_q;
    logic [7:0] lock_byte;
    logic       pol_grant;
    logic       grant_c;
    fg_op_e     op;
    fg_src_e    src;

    assign op    = fg_op_e'(req_op);
    assign src   = fg_src_e'(req_src);
    assign wen_q = ctl.wen;

    fg_ctrl_reg ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    fg_policy #(
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W),
        .USER_BYTES (USER_BYTES)
    ) policy_i (
        .src       (src),
        .op        (op),
        .addr      (req_addr),
        .ctl       (ctl),
        .lock_byte (lock_byte),
        .busy      (busy),
        .grant     (pol_grant)
    );

    assign grant_c = req_valid & pol_grant;

    fg_array #(
        .ADDR_W     (ADDR_W),
        .PAGE_W     (PAGE_W),
        .USER_BYTES (USER_BYTES)
    ) array_i (
        .clk       (clk),
        .rst       (rst),
        .do_read   (grant_c && op == OP_READ),
        .do_write  (grant_c && op == OP_WRITE),
        .do_perase (grant_c && op == OP_PERASE),
        .do_derase (grant_c && op == OP_DERASE),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .rdata     (rsp_rdata),
        .lock_byte (lock_byte)
    );

    fg_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) busy_i (
        .clk  (clk),
        .rst  (rst),
        .load (grant_c && op != OP_READ),
        .busy (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= grant_c;
        end
    end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
    parameter int ADDR_W     = 11,
    parameter int USER_BYTES = 1536
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_src,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              ctl_wen,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic [7:0]        rsp_rdata,
    input logic              busy
);
    // R1
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r1_deny_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_grant) |-> (rsp_rdata == 8'h00));
    // R2
    a_r2_cpu_write_wen: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_src && req_op == 2'd1 && !ctl_wen) |=> !rsp_grant);
    // R4
    a_r4_reserved: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != 2'd3 && 32'(req_addr) >= USER_BYTES) |=> !rsp_grant);
    // R8
    a_r8_cpu_derase: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_src && req_op == 2'd3) |=> !rsp_grant);
    // R9
    a_r9_busy_refuse: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> !rsp_grant);
    a_r9_busy_set: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_op != 2'd0) |=> (busy == rsp_grant));
endmodule

bind flash_guard flash_guard_chk #(
    .ADDR_W     (ADDR_W),
    .USER_BYTES (USER_BYTES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .ctl_wen   (wen_q),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_rdata (rsp_rdata),
    .busy      (busy)
);

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;
    localparam int ADDR_W      = 11;
    localparam int PAGE_W      = 9;
    localparam int USER_BYTES  = 1536;
    localparam int BUSY_CYCLES = 4;
    localparam int DEPTH       = 1 << ADDR_W;
    localparam int LOCK        = USER_BYTES - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctl_we = 1'b0;
    logic [1:0]        ctl_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_src = 1'b0;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_grant;
    logic [7:0]        rsp_rdata;
    logic              busy;

    always #5 clk = ~clk;

    flash_guard #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .USER_BYTES  (USER_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_grant (rsp_grant),
        .rsp_rdata (rsp_rdata),
        .busy      (busy)
    );

    typedef struct {
        logic       grant;
        logic [7:0] rdata;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] shadow [DEPTH];
    int         checks = 0;
    int         failures = 0;
    bit         done = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R1 unexpected response actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " grant"}, int'(rsp_grant), int'(e.grant));
                check({e.tag, " rdata"}, int'(rsp_rdata), int'(e.rdata));
            end
        end
    end

    task automatic issue(input logic s, input logic [1:0] o, input int a,
                         input logic [7:0] d, input logic g, input logic [7:0] rd,
                         input string tag);
        exp_t e;
        e.grant = g; e.rdata = rd; e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_src = s; req_op = o;
        req_addr = ADDR_W'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle(input logic g, input string tag);
        if (g) begin
            check({tag, " busy high"}, int'(busy), 1);
            repeat (BUSY_CYCLES) @(negedge clk);
            check({tag, " busy low"}, int'(busy), 0);
        end
    endtask

    task automatic rd(input logic s, input int a, input logic g, input string tag);
        issue(s, 2'd0, a, 8'h00, g, g ? shadow[a] : 8'h00, tag);
    endtask

    task automatic wr(input logic s, input int a, input logic [7:0] d,
                      input logic g, input string tag);
        issue(s, 2'd1, a, d, g, 8'h00, tag);
        if (g) shadow[a] = shadow[a] & d;
        settle(g, tag);
    endtask

    task automatic pe(input logic s, input int a, input logic g, input string tag);
        issue(s, 2'd2, a, 8'h00, g, 8'h00, tag);
        if (g)
            for (int i = 0; i < (1 << PAGE_W); i++)
                shadow[(a & ~((1 << PAGE_W) - 1)) + i] = 8'hFF;
        settle(g, tag);
    endtask

    task automatic de(input logic s, input logic g, input string tag);
        issue(s, 2'd3, 0, 8'h00, g, 8'h00, tag);
        if (g) for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        settle(g, tag);
    endtask

    task automatic set_ctl(input logic w, input logic e);
        ctl_we = 1'b1; ctl_wdata = {e, w};
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset rsp_valid", int'(rsp_valid), 0);
        check("R9 reset busy", int'(busy), 0);
        @(negedge clk);

        // R2: erased contents and write enable
        rd(0, 16, 1, "R2 erased read");
        wr(0, 16, 8'hAA, 0, "R2 write without enable");
        rd(0, 16, 1, "R1 denied write left byte");
        set_ctl(1, 0);                                   // R10
        wr(0, 16, 8'hAA, 1, "R10 write after enable");
        rd(0, 16, 1, "R2 written value");
        wr(0, 16, 8'h0F, 1, "R2 and-write");
        rd(0, 16, 1, "R2 and result");

        // R9: request during busy
        issue(0, 2'd1, 32, 8'h55, 1, 8'h00, "R9 write starts busy");
        shadow[32] = 8'h55;
        check("R9 busy after write", int'(busy), 1);
        issue(0, 2'd0, 16, 8'h00, 0, 8'h00, "R9 read refused while busy");
        repeat (BUSY_CYCLES) @(negedge clk);
        rd(0, 32, 1, "R9 write landed");

        // R3: page erase
        pe(0, 16'h1F0, 0, "R3 erase without erase-enable");
        rd(0, 16, 1, "R3 byte kept");
        set_ctl(1, 1);
        pe(0, 16'h1F0, 1, "R3 page erase");
        rd(0, 16, 1, "R3 page cleared low");
        rd(0, 32, 1, "R3 page cleared mid");

        // debug access unlocked
        wr(0, 16'h300, 8'h33, 1, "R2 cpu write page1");
        rd(1, 16'h300, 1, "R6 debug read unlocked");
        wr(1, 16'h301, 8'h44, 1, "R5 debug write unlocked");
        rd(0, 16'h301, 1, "R5 debug write landed");

        // R4: reserved region and lock page
        rd(0, USER_BYTES, 0, "R4 reserved read");
        wr(0, 16'h700, 8'h00, 0, "R4 reserved write");
        pe(0, 16'h400, 0, "R4 lock page erase refused");

        // R5: write lock
        wr(0, LOCK, 8'hEF, 1, "R7 cpu clears lock bit4");
        wr(1, 16'h302, 8'h00, 0, "R5 debug write locked");
        pe(1, 16'h000, 0, "R5 debug page erase locked");
        rd(1, 16'h300, 1, "R5 debug read still allowed");
        rd(1, LOCK, 1, "R7 debug read lock byte");
        rd(0, 16'h302, 1, "R5 locked write left byte");

        // R6: read lock
        wr(1, LOCK, 8'hFE, 1, "R7 debug clears lock bit0");
        rd(1, LOCK, 1, "R7 lock byte readable under read lock");
        rd(1, 16'h300, 0, "R6 debug read locked");
        rd(0, 16'h300, 1, "R7 cpu read unaffected");

        // R8: device erase
        de(0, 0, "R8 cpu device erase refused");
        rd(0, LOCK, 1, "R8 lock kept after refused erase");
        de(1, 1, "R8 debug device erase");
        rd(0, LOCK, 1, "R8 lock byte erased");
        rd(1, 16'h300, 1, "R8 debug read after unlock");
        wr(1, 16'h302, 8'h12, 1, "R8 debug write after unlock");
        rd(1, 16'h302, 1, "R8 debug write landed");

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule